// File: doc/BRIEF.md
# Overcurrent Hiccup Soft-Start Sequencer

This block governs start-up and recovery from overcurrent for a pulse-width modulator. A saturating digital counter stands in for the soft-start capacitor: it climbs by a small step each clock while the converter is allowed to start, and it drops by a much larger step after a fault. The requested duty command is limited to the counter value, so the delivered duty rises with the ramp until the request becomes the smaller of the two.

An overcurrent flag blanks the duty output in the same cycle and latches a fault on the next edge. Recovery follows a hiccup pattern. The ramp first finishes charging to the full threshold, even when the fault arrived mid-ramp. It then discharges until it is below the restart threshold. A new soft-start begins only once the overcurrent flag has also cleared. This bounds how often the converter retries into a persistent short. Loss of either the supply-good or the reference-good condition returns the block to lockout with the ramp emptied.

Top module: `hiccup_ss_seq`

## Requirements
- R1: While reset is asserted the block is in lockout: `state_o` is 0, `ss_level` is 0, `duty_out` is 0 and `fault_latch` is 0. State codes are LOCKOUT=0, CHARGE=1, RUN=2, FAULT_CHARGE=3, DISCHARGE=4, WAIT_CLEAR=5.
- R2: Lockout is left, on the next clock edge, only when `supply_ok` and `vref_ok` are both 1. The ramp is 0 on entering CHARGE.
- R3: In CHARGE, RUN and FAULT_CHARGE the level rises by CHG_STEP per clock and saturates at 2^LVL_W-1 without wrapping.
- R4: In CHARGE and RUN, with `ocp_flag` low, `duty_out` equals the smaller of `duty_req` and `ss_level`. In every other state it is 0.
- R5: A clock edge in CHARGE with level at or above FULL_LVL and no overcurrent moves the block to RUN.
- R6: `ocp_flag` high forces `duty_out` to 0 in the same cycle. From CHARGE or RUN the block enters a fault state on the next edge, with `fault_latch` at 1 in states 3, 4 and 5.
- R7: A fault taken in CHARGE enters FAULT_CHARGE. The level keeps charging there regardless of `ocp_flag`, and DISCHARGE is entered only on the edge where the level is at or above FULL_LVL.
- R8: In DISCHARGE and WAIT_CLEAR the level falls by DIS_STEP per clock and saturates at 0.
- R9: A DISCHARGE edge with level below RESTART_LVL moves the block to CHARGE if `ocp_flag` is low, or to WAIT_CLEAR if it is high. WAIT_CLEAR moves to CHARGE on the first edge with `ocp_flag` low.
- R10: From any state, an edge with `supply_ok` or `vref_ok` low returns the block to LOCKOUT with level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its undervoltage threshold |
| vref_ok | input | 1 | Reference within its valid range |
| ocp_flag | input | 1 | Overcurrent comparator output |
| duty_req | input | LVL_W | Requested duty command |
| duty_out | output | LVL_W | Duty command after soft-start clamp and fault gating |
| fault_latch | output | 1 | Fault latched; PWM outputs must be held low |
| ss_level | output | LVL_W | Soft-start ramp level |
| state_o | output | 3 | Sequencer state code |

## Verification
The bench drives four fault patterns. A one-cycle overcurrent pulse in RUN checks the immediate blanking and the full-depth discharge. A pulse during the ramp separates finish-then-discharge behaviour from an immediate discharge. An overcurrent held through the discharge separates gating on the restart threshold alone from gating on both the threshold and the cleared flag. A supply or reference drop checks that either one alone forces lockout. Duty requests above and below the ramp distinguish the clamp from a pass-through, and long ramps expose wrapping at either end of the counter.

// File: rtl/hss_pkg.sv
package hss_pkg;
   typedef enum logic [2:0] {
      HS_LOCKOUT = 3'd0,
      HS_CHARGE  = 3'd1,
      HS_RUN     = 3'd2,
      HS_FLT_CHG = 3'd3,
      HS_DISCH   = 3'd4,
      HS_WAIT    = 3'd5
   } hs_state_t;

   function automatic logic hs_is_fault(hs_state_t s);
      return (s == HS_FLT_CHG) || (s == HS_DISCH) || (s == HS_WAIT);
   endfunction

   function automatic logic hs_is_drive(hs_state_t s);
      return (s == HS_CHARGE) || (s == HS_RUN);
   endfunction
endpackage

// File: rtl/hss_level.sv
module hss_level
   import hss_pkg::*;
#(
   parameter int LVL_W       = 10,
   parameter int CHG_STEP    = 9,
   parameter int DIS_STEP    = 250,
   parameter int FULL_LVL    = 900,
   parameter int RESTART_LVL = 90
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_ok,
   input  hs_state_t        state,
   output logic [LVL_W-1:0] level,
   output logic             at_full,
   output logic             below_restart
);
   localparam logic [LVL_W-1:0] CHG_V  = LVL_W'(CHG_STEP);
   localparam logic [LVL_W-1:0] DIS_V  = LVL_W'(DIS_STEP);
   localparam logic [LVL_W-1:0] FULL_V = LVL_W'(FULL_LVL);
   localparam logic [LVL_W-1:0] RST_V  = LVL_W'(RESTART_LVL);

   logic [LVL_W:0]   up_sum;
   logic [LVL_W-1:0] up_sat;
   logic [LVL_W-1:0] dn_sat;
   logic [LVL_W-1:0] level_nx;

   assign up_sum = {1'b0, level} + {1'b0, CHG_V};

   generate
      if (FULL_LVL == (1 << LVL_W) - 1) begin : g_full_top
         // Full threshold equals full scale: detection reduces to all ones.
         assign at_full = &level;
      end else begin : g_full_cmp
         assign at_full = (level >= FULL_V);
      end
   endgenerate

   assign up_sat        = up_sum[LVL_W] ? '1 : up_sum[LVL_W-1:0];
   assign dn_sat        = (level >= DIS_V) ? (level - DIS_V) : '0;
   assign below_restart = (level < RST_V);

   always_comb begin
      level_nx = '0;
      if (pwr_ok) begin
         unique case (state)
            HS_CHARGE, HS_RUN, HS_FLT_CHG: level_nx = up_sat;
            HS_DISCH, HS_WAIT:             level_nx = dn_sat;
            default:                       level_nx = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level <= '0;
      else        level <= level_nx;
   end
endmodule

// File: rtl/hss_fsm.sv
module hss_fsm
   import hss_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pwr_ok,
   input  logic      ocp,
   input  logic      at_full,
   input  logic      below_restart,
   output hs_state_t state
);
   hs_state_t state_nx;

   always_comb begin
      state_nx = state;
      if (!pwr_ok) begin
         state_nx = HS_LOCKOUT;
      end else begin
         unique case (state)
            HS_LOCKOUT: state_nx = HS_CHARGE;
            HS_CHARGE: begin
               if (ocp)          state_nx = HS_FLT_CHG;
               else if (at_full) state_nx = HS_RUN;
            end
            HS_RUN:     if (ocp) state_nx = HS_DISCH;
            HS_FLT_CHG: if (at_full) state_nx = HS_DISCH;
            HS_DISCH: begin
               if (below_restart) state_nx = ocp ? HS_WAIT : HS_CHARGE;
            end
            HS_WAIT:    if (!ocp) state_nx = HS_CHARGE;
            default:    state_nx = HS_LOCKOUT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= HS_LOCKOUT;
      else        state <= state_nx;
   end
endmodule

// File: rtl/hss_clamp.sv
module hss_clamp
   import hss_pkg::*;
#(
   parameter int LVL_W    = 10,
   parameter bit OCP_FAST = 1'b1
) (
   input  hs_state_t        state,
   input  logic             ocp,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] req,
   output logic [LVL_W-1:0] duty
);
   logic [LVL_W-1:0] lim;
   logic             pass;

   assign lim = (req < level) ? req : level;

   generate
      if (OCP_FAST) begin : g_fast_blank
         assign pass = hs_is_drive(state) && !ocp;
      end else begin : g_latched_blank
         assign pass = hs_is_drive(state);
      end
   endgenerate

   assign duty = pass ? lim : '0;
endmodule

// File: rtl/hiccup_ss_seq.sv
module hiccup_ss_seq
   import hss_pkg::*;
#(
   parameter int LVL_W       = 10,
   parameter int CHG_STEP    = 9,
   parameter int DIS_STEP    = 250,
   parameter int FULL_LVL    = 900,
   parameter int RESTART_LVL = 90,
   parameter bit OCP_FAST    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_ok,
   input  logic             vref_ok,
   input  logic             ocp_flag,
   input  logic [LVL_W-1:0] duty_req,
   output logic [LVL_W-1:0] duty_out,
   output logic             fault_latch,
   output logic [LVL_W-1:0] ss_level,
   output logic [2:0]       state_o
);
   localparam int LVL_TOP = (1 << LVL_W) - 1;

   generate
      if (LVL_W < 2 || LVL_W > 24) begin : g_bad_width
         $error("hiccup_ss_seq: LVL_W out of range");
      end
      if (CHG_STEP < 1 || CHG_STEP > LVL_TOP) begin : g_bad_chg
         $error("hiccup_ss_seq: CHG_STEP out of range");
      end
      if (DIS_STEP <= CHG_STEP || DIS_STEP > LVL_TOP) begin : g_bad_dis
         $error("hiccup_ss_seq: DIS_STEP must exceed CHG_STEP and fit");
      end
      if (FULL_LVL > LVL_TOP || RESTART_LVL < 1 || RESTART_LVL >= FULL_LVL) begin : g_bad_thr
         $error("hiccup_ss_seq: thresholds must satisfy 0 < RESTART < FULL <= top");
      end
   endgenerate

   logic      pwr_ok;
   logic      at_full;
   logic      below_restart;
   hs_state_t state;

   assign pwr_ok = supply_ok & vref_ok;

   hss_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .pwr_ok        (pwr_ok),
      .ocp           (ocp_flag),
      .at_full       (at_full),
      .below_restart (below_restart),
      .state         (state)
   );

   hss_level #(
      .LVL_W       (LVL_W),
      .CHG_STEP    (CHG_STEP),
      .DIS_STEP    (DIS_STEP),
      .FULL_LVL    (FULL_LVL),
      .RESTART_LVL (RESTART_LVL)
   ) u_level (
      .clk           (clk),
      .rst_n         (rst_n),
      .pwr_ok        (pwr_ok),
      .state         (state),
      .level         (ss_level),
      .at_full       (at_full),
      .below_restart (below_restart)
   );

   hss_clamp #(
      .LVL_W    (LVL_W),
      .OCP_FAST (OCP_FAST)
   ) u_clamp (
      .state (state),
      .ocp   (ocp_flag),
      .level (ss_level),
      .req   (duty_req),
      .duty  (duty_out)
   );

   assign fault_latch = hs_is_fault(state);
   assign state_o     = state;
endmodule

// File: rtl/hiccup_ss_chk.sv
module hiccup_ss_chk #(
   parameter int LVL_W       = 10,
   parameter int CHG_STEP    = 9,
   parameter int DIS_STEP    = 250,
   parameter int FULL_LVL    = 900,
   parameter int RESTART_LVL = 90
) (
   input logic             clk,
   input logic             rst_n,
   input logic             supply_ok,
   input logic             vref_ok,
   input logic             ocp_flag,
   input logic [LVL_W-1:0] duty_out,
   input logic             fault_latch,
   input logic [LVL_W-1:0] ss_level,
   input logic [2:0]       state_o
);
   localparam logic [LVL_W-1:0] CHG_V  = LVL_W'(CHG_STEP);
   localparam logic [LVL_W-1:0] DIS_V  = LVL_W'(DIS_STEP);
   localparam logic [LVL_W-1:0] FULL_V = LVL_W'(FULL_LVL);
   localparam logic [LVL_W-1:0] RST_V  = LVL_W'(RESTART_LVL);
   localparam logic [LVL_W-1:0] TOP_V  = '1;

   logic ok;
   assign ok = supply_ok & vref_ok;

   // R10 / R1
   p_lockout_on_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ok |=> (state_o == 3'd0) && (ss_level == '0));

   // R6
   p_fault_blanks_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ocp_flag || fault_latch) |-> (duty_out == '0));

   // R4
   p_duty_below_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      duty_out <= ss_level);

   // R3
   p_charge_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ok && (state_o == 3'd1) && (ss_level <= TOP_V - CHG_V)
      |=> ss_level == $past(ss_level) + CHG_V);

   // R8
   p_discharge_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ok && ((state_o == 3'd4) || (state_o == 3'd5)) && (ss_level >= DIS_V)
      |=> ss_level == $past(ss_level) - DIS_V);

   // R7
   p_fault_charge_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ok && (state_o == 3'd3) && (ss_level < FULL_V) |=> state_o == 3'd3);

   // R9
   p_restart_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_o == 3'd4) || (state_o == 3'd5)) && (ocp_flag || ss_level >= RST_V)
      |=> state_o != 3'd1);

   // R5
   p_run_at_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ok && (state_o == 3'd1) && !ocp_flag && (ss_level >= FULL_V) |=> state_o == 3'd2);

   // R1: legal codes only
   p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      state_o <= 3'd5);
endmodule

bind hiccup_ss_seq hiccup_ss_chk #(
   .LVL_W       (LVL_W),
   .CHG_STEP    (CHG_STEP),
   .DIS_STEP    (DIS_STEP),
   .FULL_LVL    (FULL_LVL),
   .RESTART_LVL (RESTART_LVL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .supply_ok   (supply_ok),
   .vref_ok     (vref_ok),
   .ocp_flag    (ocp_flag),
   .duty_out    (duty_out),
   .fault_latch (fault_latch),
   .ss_level    (ss_level),
   .state_o     (state_o)
);

// File: tb/hiccup_ss_seq_tb.sv
module hiccup_ss_seq_tb;
   localparam int W    = 10;
   localparam int CHG  = 9;
   localparam int DIS  = 250;
   localparam int FULL = 900;
   localparam int RSTL = 90;
   localparam int TOP  = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         supply_ok = 1'b0;
   logic         vref_ok = 1'b0;
   logic         ocp_flag = 1'b0;
   logic [W-1:0] duty_req = '0;
   logic [W-1:0] duty_out;
   logic         fault_latch;
   logic [W-1:0] ss_level;
   logic [2:0]   state_o;

   always #2 clk = ~clk;

   hiccup_ss_seq u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_ok   (supply_ok),
      .vref_ok     (vref_ok),
      .ocp_flag    (ocp_flag),
      .duty_req    (duty_req),
      .duty_out    (duty_out),
      .fault_latch (fault_latch),
      .ss_level    (ss_level),
      .state_o     (state_o)
   );

   // Behavioural reference: state number and ramp value as integers.
   int m_st = 0;
   int m_lv = 0;

   always @(posedge clk or negedge rst_n) begin
      int ns;
      int nl;
      if (!rst_n) begin
         m_st = 0;
         m_lv = 0;
      end else if (!(supply_ok && vref_ok)) begin
         m_st = 0;
         m_lv = 0;
      end else begin
         ns = m_st;
         nl = m_lv;
         if (m_st >= 1 && m_st <= 3) nl = (m_lv + CHG > TOP) ? TOP : m_lv + CHG;
         else if (m_st >= 4)         nl = (m_lv < DIS) ? 0 : m_lv - DIS;
         else                        nl = 0;
         case (m_st)
            0: ns = 1;
            1: ns = ocp_flag ? 3 : (m_lv >= FULL ? 2 : 1);
            2: ns = ocp_flag ? 4 : 2;
            3: ns = (m_lv >= FULL) ? 4 : 3;
            4: ns = (m_lv < RSTL) ? (ocp_flag ? 5 : 1) : 4;
            default: ns = ocp_flag ? 5 : 1;
         endcase
         m_st = ns;
         m_lv = nl;
      end
   end

   function automatic int m_duty();
      if ((m_st == 1 || m_st == 2) && !ocp_flag)
         return (int'(duty_req) < m_lv) ? int'(duty_req) : m_lv;
      return 0;
   endfunction

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the model.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R5 state vs model", int'(state_o), m_st);
         chk("R3 level vs model", int'(ss_level), m_lv);
         chk("R4 duty vs model", int'(duty_out), m_duty());
         chk("R6 fault vs model", int'(fault_latch), (m_st >= 3) ? 1 : 0);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wait_state(input int s, input int limit);
      for (int i = 0; i < limit; i++) begin
         if (int'(state_o) == s) return;
         step(1);
      end
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #400000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      step(3);
      // R1: reset state
      chk("R1 reset state", int'(state_o), 0);
      chk("R1 reset level", int'(ss_level), 0);
      chk("R1 reset duty", int'(duty_out), 0);
      chk("R1 reset fault", int'(fault_latch), 0);
      rst_n = 1'b1;

      // R2: one good flag alone is not enough
      supply_ok = 1'b1;
      step(5);
      chk("R2 supply only stays locked", int'(state_o), 0);
      supply_ok = 1'b0;
      vref_ok = 1'b1;
      step(3);
      chk("R2 vref only stays locked", int'(state_o), 0);
      supply_ok = 1'b1;
      step(1);
      chk("R2 release to charge", int'(state_o), 1);
      chk("R2 ramp starts empty", int'(ss_level), 0);

      // R3 / R4: ramp and clamp
      step(10);
      chk("R3 ten charge steps", int'(ss_level), 10 * CHG);
      duty_req = 10'd50;
      #1;
      chk("R4 request below ramp", int'(duty_out), 50);
      duty_req = 10'd1000;
      #1;
      chk("R4 request above ramp", int'(duty_out), 10 * CHG);

      // R5: enter RUN at full threshold (CHARGE edge at 900 also steps to 909)
      wait_state(2, 200);
      chk("R5 reached run", int'(state_o), 2);
      chk("R5 level on entering run", int'(ss_level), FULL + CHG);
      step(20);
      chk("R3 saturates at top", int'(ss_level), TOP);
      chk("R4 clamp by request in run", int'(duty_out), 1000);

      // R6: single-cycle overcurrent in RUN
      ocp_flag = 1'b1;
      #1;
      chk("R6 same-cycle blanking", int'(duty_out), 0);
      step(1);
      ocp_flag = 1'b0;
      chk("R6 fault latched", int'(fault_latch), 1);
      chk("R6 enters discharge", int'(state_o), 4);
      chk("R6 duty stays low", int'(duty_out), 0);
      step(1);
      chk("R8 one discharge step", int'(ss_level), TOP - DIS);
      step(3);
      chk("R8 discharge continues", int'(ss_level), TOP - 4 * DIS);
      chk("R9 still discharging above restart", int'(state_o), 4);
      step(1);
      chk("R9 restart after clear", int'(state_o), 1);
      chk("R8 saturates at zero", int'(ss_level), 0);

      // R7: fault during the ramp
      step(20);
      chk("R7 ramp before fault", int'(ss_level), 20 * CHG);
      ocp_flag = 1'b1;
      step(1);
      ocp_flag = 1'b0;
      chk("R7 fault charge state", int'(state_o), 3);
      step(1);
      chk("R7 keeps charging", int'(ss_level), 22 * CHG);
      chk("R7 no early discharge", int'(state_o), 3);
      wait_state(4, 200);
      chk("R7 discharge after full", int'(ss_level), FULL + CHG);
      wait_state(1, 50);
      chk("R9 restart after hiccup", int'(state_o), 1);

      // R9: overcurrent held through discharge
      wait_state(2, 300);
      ocp_flag = 1'b1;
      wait_state(5, 50);
      chk("R9 waits for clear", int'(state_o), 5);
      step(5);
      chk("R9 still waiting", int'(state_o), 5);
      chk("R8 floor while waiting", int'(ss_level), 0);
      ocp_flag = 1'b0;
      step(1);
      chk("R9 restart once clear", int'(state_o), 1);

      // R10: reference loss in RUN
      wait_state(2, 300);
      vref_ok = 1'b0;
      step(1);
      chk("R10 lockout on vref loss", int'(state_o), 0);
      chk("R10 ramp cleared", int'(ss_level), 0);
      vref_ok = 1'b1;
      step(1);
      chk("R10 recover to charge", int'(state_o), 1);
      step(2);

      finish_run();
   end
endmodule